// File: doc/BRIEF.md
# Radix Page-Table Walker

This block translates a 64-bit effective address into a real address by walking a multi-level radix tree stored in memory. A walk begins from a single 64-bit root descriptor, which encodes three things: the base of the top-level directory, the width of the index used at the top level, and the total number of address bits the tree translates. The walker fetches one 64-bit entry per level through a simple request/response read port. It follows directory entries until it reaches a leaf. It then reports the real address, the final page size (in address bits), the leaf entry, and a fault cause.

Each level is shaped by the entry above it. A directory entry supplies the base of the next table and the index width for the next level. The translated size drops by the index width of every level that is consumed. Before every read, the current level's shape is validated against a fixed table of allowed shapes. A directory base that is not aligned to its table size is silently realigned rather than faulted.

The block is used by an address-translation front end. That front end pulses `start` with the address and root descriptor, then waits for `done`. Protection checks, caching of results and second-stage translation are handled elsewhere.

Top module: `radix_walker`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `done`, `fault` and `req_valid` are low, and `fault_cause` reads 0 after reset.
- R2: On an accepted `start`, the starting translated size is 31 plus a 5-bit value. That value has `root_desc[62]` as bit 4, `root_desc[61]` as bit 3, and `root_desc[7:5]` as bits 2:0. The top-level base is `root_desc & 0x0FFFFFFFFFFFFF00`, and the top-level index width is `root_desc[4:0]`.
- R3: For a level of index width n and current size s, each read uses address `base' + 8*((ea >> (s-n)) & (2^n-1))`. Every read address is therefore 8-byte aligned.
- R4: The base used in R3 is the directory base with its low n+3 bits forced to zero. A misaligned base is realigned and never faulted.
- R5: Before each read, the level is validated:
  - level 0 needs size 52 and width 13;
  - levels 1 and 2 need width 9;
  - level 3 needs width 9 or 5;
  - level 4 and deeper always fail.

  A failed check ends the walk with `fault_cause` = 2 (bad shape) and issues no read for that level.
- R6: An entry with bit 63 clear ends the walk with `fault_cause` = 1 (no entry).
- R7: After each valid entry, the size drops by the current width. An entry with bit 62 clear is a directory: the next width is its bits 4:0, and the next base is the entry masked with `0x0FFFFFFFFFFFFF00`.
- R8: An entry with bits 63 and 62 both set is a leaf. The walk then ends with `fault` low and `fault_cause` = 0. `page_size` is the reduced size s, `leaf_entry` is the entry, and `real_addr` is `(entry & 0x01FFFFFFFFFFF000 & ~(2^s-1)) | (ea & (2^s-1))`.
- R9: A read request is held, with its address unchanged, until `req_ready` is high. Exactly one read is issued per level reached, and no new request is made until the response arrives.
- R10: `start` is ignored while a walk is in progress. A walk's result depends only on the `ea` and `root_desc` captured when it was accepted.
- R11: `done` is high for exactly one cycle per walk. `fault` is high only in that cycle, and only with a nonzero `fault_cause`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (accepted only when idle) |
| ea | input | 64 | Effective address to translate |
| root_desc | input | 64 | Root descriptor: base, top index width, encoded size |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | 64 | Read address of the table entry |
| resp_valid | input | 1 | Read data valid |
| resp_data | input | 64 | Table entry returned by memory |
| done | output | 1 | One-cycle completion strobe |
| fault | output | 1 | Walk ended in a fault (with `done`) |
| fault_cause | output | 2 | 0 none, 1 no entry, 2 bad shape |
| real_addr | output | 64 | Translated real address |
| page_size | output | 7 | Final page size in address bits |
| leaf_entry | output | 64 | Last entry read (the leaf on success) |

## Verification
Some properties are checked by assertions on every cycle:
- the quiet state after reset;
- that a stalled request holds its address;
- that request addresses are 8-byte aligned;
- that the completion strobe lasts a single cycle;
- that a fault always carries a cause, while a clean completion carries none.

The translation itself can only be shown by scenarios run against a small in-memory tree. Those scenarios cover leaves at every depth, including the 5-bit last level. They also cover realignment of an unaligned directory base, missing entries, shape failures at the root and at deeper levels, an over-deep tree, a `start` pulse during a walk, and request stalls with varying response latency.

// File: rtl/radix_walk_pkg.sv
package radix_walk_pkg;

    localparam int DATA_W   = 64;
    localparam int NLS_W    = 5;
    localparam int SIZE_W   = 7;
    localparam int LVL_W    = 3;
    localparam int CAUSE_W  = 2;

    localparam int VALID_BIT   = 63;
    localparam int LEAF_BIT    = 62;
    localparam int ENTRY_SHIFT = 3;   // 8-byte entries

    localparam logic [DATA_W-1:0] NEXT_BASE_MASK = 64'h0FFF_FFFF_FFFF_FF00;
    localparam logic [DATA_W-1:0] RPN_MASK       = 64'h01FF_FFFF_FFFF_F000;

    localparam int SIZE_BIAS      = 31;
    localparam int ROOT_SIZE      = 52;
    localparam int ROOT_NLS       = 13;
    localparam int MID_NLS        = 9;
    localparam int TAIL_NLS_SMALL = 5;
    localparam int LAST_LEVEL     = 3;

    localparam logic [CAUSE_W-1:0] CAUSE_NONE      = 2'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_NO_ENTRY  = 2'd1;
    localparam logic [CAUSE_W-1:0] CAUSE_BAD_SHAPE = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_READ,
        ST_WAIT,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

    typedef struct packed {
        walk_state_e          state;
        logic [DATA_W-1:0]    ea;
        logic [DATA_W-1:0]    base;
        logic [NLS_W-1:0]     nls;
        logic [SIZE_W-1:0]    size;
        logic [LVL_W-1:0]     level;
        logic [DATA_W-1:0]    entry;
        logic [DATA_W-1:0]    ra;
        logic [CAUSE_W-1:0]   cause;
    } walk_regs_t;

endpackage

// File: rtl/radix_level_check.sv
module radix_level_check
    import radix_walk_pkg::*;
(
    input  logic [LVL_W-1:0]  level,
    input  logic [SIZE_W-1:0] size,
    input  logic [NLS_W-1:0]  nls,
    output logic              shape_ok
);
    always_comb begin
        unique case (level)
            LVL_W'(0):          shape_ok = (size == SIZE_W'(ROOT_SIZE)) && (nls == NLS_W'(ROOT_NLS));
            LVL_W'(1),
            LVL_W'(2):          shape_ok = (nls == NLS_W'(MID_NLS));
            LVL_W'(LAST_LEVEL): shape_ok = (nls == NLS_W'(MID_NLS)) || (nls == NLS_W'(TAIL_NLS_SMALL));
            default:            shape_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/radix_index_calc.sv
module radix_index_calc
    import radix_walk_pkg::*;
(
    input  logic [DATA_W-1:0] ea,
    input  logic [DATA_W-1:0] base,
    input  logic [SIZE_W-1:0] size,
    input  logic [NLS_W-1:0]  nls,
    output logic [DATA_W-1:0] entry_addr
);
    localparam int AW = SIZE_W;

    logic [AW-1:0]     shift_amt;
    logic [AW-1:0]     align_bits;
    logic [DATA_W-1:0] idx_mask;
    logic [DATA_W-1:0] align_mask;
    logic [DATA_W-1:0] index;
    logic [DATA_W-1:0] base_aligned;

    always_comb begin
        shift_amt    = size - AW'(nls);
        align_bits   = AW'(nls) + AW'(ENTRY_SHIFT);
        idx_mask     = (DATA_W'(1) << nls) - DATA_W'(1);
        align_mask   = (DATA_W'(1) << align_bits) - DATA_W'(1);
        index        = (ea >> shift_amt) & idx_mask;
        base_aligned = base & ~align_mask;
        entry_addr   = base_aligned + (index << ENTRY_SHIFT);
    end
endmodule

// File: rtl/radix_leaf_form.sv
module radix_leaf_form
    import radix_walk_pkg::*;
(
    input  logic [DATA_W-1:0] entry,
    input  logic [DATA_W-1:0] ea,
    input  logic [SIZE_W-1:0] size,
    output logic [DATA_W-1:0] real_addr
);
    logic [DATA_W-1:0] page_mask;

    always_comb begin
        page_mask = (DATA_W'(1) << size) - DATA_W'(1);
        real_addr = (entry & RPN_MASK & ~page_mask) | (ea & page_mask);
    end
endmodule

// File: rtl/radix_walker.sv
module radix_walker
    import radix_walk_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [63:0]         ea,
    input  logic [63:0]         root_desc,
    output logic                req_valid,
    input  logic                req_ready,
    output logic [63:0]         req_addr,
    input  logic                resp_valid,
    input  logic [63:0]         resp_data,
    output logic                done,
    output logic                fault,
    output logic [1:0]          fault_cause,
    output logic [63:0]         real_addr,
    output logic [6:0]          page_size,
    output logic [63:0]         leaf_entry
);
    walk_regs_t r_q, r_d;

    logic              shape_ok;
    logic [DATA_W-1:0] leaf_ra;
    logic [SIZE_W-1:0] size_after;
    logic [SIZE_W-1:0] root_size;

    radix_level_check u_check (
        .level    (r_q.level),
        .size     (r_q.size),
        .nls      (r_q.nls),
        .shape_ok (shape_ok)
    );

    radix_index_calc u_index (
        .ea         (r_q.ea),
        .base       (r_q.base),
        .size       (r_q.size),
        .nls        (r_q.nls),
        .entry_addr (req_addr)
    );

    radix_leaf_form u_leaf (
        .entry     (resp_data),
        .ea        (r_q.ea),
        .size      (size_after),
        .real_addr (leaf_ra)
    );

    always_comb begin
        size_after = r_q.size - SIZE_W'(r_q.nls);
        root_size  = SIZE_W'({root_desc[62:61], root_desc[7:5]}) + SIZE_W'(SIZE_BIAS);
        r_d        = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state = ST_CHECK;
                    r_d.ea    = ea;
                    r_d.base  = root_desc & NEXT_BASE_MASK;
                    r_d.nls   = root_desc[NLS_W-1:0];
                    r_d.size  = root_size;
                    r_d.level = '0;
                    r_d.cause = CAUSE_NONE;
                end
            end
            ST_CHECK: begin
                if (shape_ok) begin
                    r_d.state = ST_READ;
                end else begin
                    r_d.cause = CAUSE_BAD_SHAPE;
                    r_d.state = ST_FAULT;
                end
            end
            ST_READ: begin
                if (req_ready) r_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (resp_valid) begin
                    if (!resp_data[VALID_BIT]) begin
                        r_d.cause = CAUSE_NO_ENTRY;
                        r_d.state = ST_FAULT;
                    end else begin
                        r_d.entry = resp_data;
                        r_d.size  = size_after;
                        if (resp_data[LEAF_BIT]) begin
                            r_d.ra    = leaf_ra;
                            r_d.state = ST_DONE;
                        end else begin
                            r_d.nls   = resp_data[NLS_W-1:0];
                            r_d.base  = resp_data & NEXT_BASE_MASK;
                            r_d.level = r_q.level + LVL_W'(1);
                            r_d.state = ST_CHECK;
                        end
                    end
                end
            end
            ST_DONE, ST_FAULT: r_d.state = ST_IDLE;
            default:           r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign req_valid   = (r_q.state == ST_READ);
    assign done        = (r_q.state == ST_DONE) || (r_q.state == ST_FAULT);
    assign fault       = (r_q.state == ST_FAULT);
    assign fault_cause = r_q.cause;
    assign real_addr   = r_q.ra;
    assign page_size   = r_q.size;
    assign leaf_entry  = r_q.entry;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!done && !fault && !req_valid)); // R1

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr))); // R9

    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_addr[2:0] == 3'b000)); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11

    AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        fault |-> (done && fault_cause != CAUSE_NONE)); // R11

    AST_CLEAN_DONE: assert property (@(posedge clk) disable iff (rst)
        (done && !fault) |-> (fault_cause == CAUSE_NONE)); // R8

endmodule

// File: tb/radix_walker_tb.sv
module radix_walker_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [63:0] ea = '0;
    logic [63:0] root_desc = '0;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [63:0] req_addr;
    logic        resp_valid = 1'b0;
    logic [63:0] resp_data = '0;
    logic        done, fault;
    logic [1:0]  fault_cause;
    logic [63:0] real_addr, leaf_entry;
    logic [6:0]  page_size;

    always #5 clk = ~clk;

    radix_walker u_dut (
        .clk(clk), .rst(rst), .start(start), .ea(ea), .root_desc(root_desc),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .resp_valid(resp_valid), .resp_data(resp_data),
        .done(done), .fault(fault), .fault_cause(fault_cause),
        .real_addr(real_addr), .page_size(page_size), .leaf_entry(leaf_entry)
    );

    // Tree image in memory
    localparam int NM = 14;
    localparam logic [63:0] MEM_A [NM] = '{
        64'h10008, 64'h10010, 64'h10020, 64'h10028,
        64'h20000, 64'h20008, 64'h30010,
        64'h40000, 64'h40008, 64'h40010,
        64'h50000, 64'h50008, 64'h60018, 64'h70000 };
    localparam logic [63:0] MEM_D [NM] = '{
        64'h8000_0000_0002_00E9, 64'hC400_1230_0000_01F3,
        64'h8000_0000_0008_0005, 64'h8000_0000_0003_0109,
        64'h8000_0000_0004_0009, 64'hC000_0000_ABCD_E105,
        64'hC000_0000_5550_0107,
        64'h8000_0000_0005_0009, 64'h8000_0000_0006_0005,
        64'hC000_0777_7760_0103,
        64'hC000_0000_1234_5187, 64'h8000_0000_0007_0009,
        64'hC000_00FE_DC00_0105, 64'hC000_0000_0000_0101 };

    localparam logic [63:0] D_OK       = 64'h4000_0000_0001_00AD;
    localparam logic [63:0] D_BAD_NLS  = 64'h4000_0000_0001_00AC;
    localparam logic [63:0] D_BAD_SIZE = 64'h4000_0000_0001_008D;

    // Vector table: desc, ea, stall, latency, expected cause/size/reads
    localparam int NV = 12;
    localparam logic [63:0] V_DESC [NV] = '{
        D_OK, D_OK, D_OK, D_OK, D_OK, D_OK, D_OK, D_OK, D_OK,
        D_BAD_NLS, D_BAD_SIZE, D_OK };
    localparam logic [63:0] V_EA [NV] = '{
        64'h0000_0080_0000_0ABC, 64'hF000_0112_3456_789A,
        64'h0000_0180_0000_0040, 64'h0000_0080_5234_5678,
        64'h0000_0080_0041_ABCD, 64'h0000_0080_0023_4567,
        64'h0000_0080_0000_1010, 64'h0000_0200_0000_0000,
        64'h0000_0280_8765_4321, 64'h0000_0080_0000_0ABC,
        64'h0000_0080_0000_0ABC, 64'h0000_0080_0000_2000 };
    localparam int V_STALL [NV] = '{0, 2, 1, 0, 3, 1, 0, 2, 1, 0, 0, 3};
    localparam int V_LAT   [NV] = '{0, 1, 3, 2, 0, 1, 2, 0, 3, 0, 0, 1};
    localparam int V_CAUSE [NV] = '{0, 0, 1, 0, 0, 0, 2, 2, 0, 2, 2, 1};
    localparam int V_SIZE  [NV] = '{12, 39, 0, 30, 21, 16, 0, 0, 30, 0, 0, 0};
    localparam int V_READS [NV] = '{4, 1, 1, 2, 3, 4, 4, 1, 2, 0, 0, 4};

    int checks = 0;
    int errors = 0;

    int          stall_cfg = 0, stall_cnt = 0, lat_cfg = 0, resp_cnt = 0, reads = 0;
    logic [63:0] pend_addr = '0;
    logic [63:0] req_log [8];
    logic [63:0] exp_addr [8];
    int          exp_n;
    logic [63:0] exp_ra, exp_entry;

    function automatic logic [63:0] mem_read(input logic [63:0] a);
        for (int i = 0; i < NM; i++)
            if (MEM_A[i] == a) return MEM_D[i];
        return 64'h0;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Bench model of the walk, written from the requirements
    task automatic ref_walk(input logic [63:0] d, input logic [63:0] a);
        int          size, nls;
        logic [63:0] base, ab, idx, e;
        bit          ok;
        size = int'({d[62:61], d[7:5]}) + 31;
        nls  = int'(d[4:0]);
        base = d & 64'h0FFF_FFFF_FFFF_FF00;
        exp_n = 0; exp_ra = '0; exp_entry = '0;
        for (int lvl = 0; lvl < 5; lvl++) begin
            if (lvl == 0)      ok = (size == 52) && (nls == 13);
            else if (lvl < 3)  ok = (nls == 9);
            else if (lvl == 3) ok = (nls == 9) || (nls == 5);
            else               ok = 1'b0;
            if (!ok) break;
            ab  = base & ~((64'd1 << (nls + 3)) - 64'd1);
            idx = (a >> (size - nls)) & ((64'd1 << nls) - 64'd1);
            exp_addr[exp_n] = ab + idx * 8;
            e = mem_read(exp_addr[exp_n]);
            exp_n++;
            if (!e[63]) break;
            size = size - nls;
            exp_entry = e;
            if (e[62]) begin
                exp_ra = (e & 64'h01FF_FFFF_FFFF_F000 & ~((64'd1 << size) - 64'd1))
                       | (a & ((64'd1 << size) - 64'd1));
                break;
            end
            nls  = int'(e[4:0]);
            base = e & 64'h0FFF_FFFF_FFFF_FF00;
        end
    endtask

    // Memory responder: grants after stall_cfg cycles, answers after lat_cfg
    initial begin
        forever begin
            @(negedge clk);
            resp_valid = 1'b0;
            if (resp_cnt != 0) begin
                resp_cnt--;
                if (resp_cnt == 0) begin
                    resp_valid = 1'b1;
                    resp_data  = mem_read(pend_addr);
                end
            end
            if (req_valid && !req_ready) begin
                if (stall_cnt == 0) begin
                    req_ready = 1'b1;
                    pend_addr = req_addr;
                    resp_cnt  = lat_cfg + 1;
                    if (reads < 8) req_log[reads] = req_addr;
                    reads++;
                    stall_cnt = stall_cfg;
                end else begin
                    stall_cnt--;
                end
            end else begin
                req_ready = 1'b0;
            end
        end
    end

    task automatic launch(input logic [63:0] d, input logic [63:0] a, input int st, input int lt);
        @(negedge clk);
        root_desc = d; ea = a;
        stall_cfg = st; stall_cnt = st; lat_cfg = lt; reads = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int cyc = 0;
        while (!done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL R11 watchdog act=no_done exp=done");
        end
    endtask

    task automatic check_result(input int v, input int cause, input int size, input int nreads);
        chk($sformatf("R5/R6 v%0d cause", v), 64'(fault_cause), 64'(cause));
        chk($sformatf("R11 v%0d fault flag", v), 64'(fault), 64'(cause != 0));
        chk($sformatf("R9 v%0d read count", v), 64'(reads), 64'(nreads));
        chk($sformatf("R9 v%0d model reads", v), 64'(exp_n), 64'(nreads));
        for (int i = 0; i < 8; i++)
            if (i < exp_n && i < reads)
                chk($sformatf("R3 R4 v%0d addr%0d", v, i), req_log[i], exp_addr[i]);
        if (cause == 0) begin
            chk($sformatf("R8 v%0d real_addr", v), real_addr, exp_ra);
            chk($sformatf("R7 v%0d page_size", v), 64'(page_size), 64'(size));
            chk($sformatf("R8 v%0d leaf_entry", v), leaf_entry, exp_entry);
        end
        @(negedge clk);
        chk($sformatf("R11 v%0d done one cycle", v), 64'(done), 64'd0);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 done in reset", 64'(done), 64'd0);
        chk("R1 fault in reset", 64'(fault), 64'd0);
        chk("R1 req_valid in reset", 64'(req_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 done after reset", 64'(done), 64'd0);
        chk("R1 cause after reset", 64'(fault_cause), 64'd0);

        for (int v = 0; v < NV; v++) begin
            ref_walk(V_DESC[v], V_EA[v]);
            launch(V_DESC[v], V_EA[v], V_STALL[v], V_LAT[v]);
            wait_done();
            check_result(v, V_CAUSE[v], V_SIZE[v], V_READS[v]);
        end

        // R2: top-level address from the root descriptor
        ref_walk(D_OK, V_EA[0]);
        chk("R2 root entry addr", exp_addr[0], 64'h10008);

        // R10: start during a walk is ignored
        ref_walk(D_OK, V_EA[3]);
        launch(D_OK, V_EA[3], 3, 2);
        repeat (3) @(negedge clk);
        root_desc = D_BAD_NLS; ea = V_EA[1];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk("R10 real_addr unchanged by late start", real_addr, exp_ra);
        chk("R10 cause unchanged by late start", 64'(fault_cause), 64'd0);
        chk("R10 read count", 64'(reads), 64'd2);
        @(negedge clk);
        @(negedge clk);
        chk("R10 no walk after ignored start", 64'(req_valid), 64'd0);

        // R1: reset in the middle of a walk
        launch(D_OK, V_EA[0], 2, 2);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 mid-walk reset done", 64'(done), 64'd0);
        chk("R1 mid-walk reset req", 64'(req_valid), 64'd0);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        chk("R1 idle after reset", 64'(req_valid), 64'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule